// File: doc/BRIEF.md
# Adaptive Run-Ahead Token Throttle

This block limits how far a prefetching engine may run ahead of the engine that issues the matching loads. The prefetch side offers one token each time it has issued the prefetches for an iteration. The load side takes one token before it issues that iteration's loads, and it waits while the queue is empty. The tokens carry no data. The queue only tracks how many are outstanding, up to a physical depth `DEPTH`.

The number of tokens the queue will accept is a run-time limit. It is retuned every `WINDOW` accepted pops. Two per-load outcome pulses feed two counters. One pulse marks a prefetch whose data arrived after its load had issued (late). The other marks a prefetch whose data arrived before its load issued (useful). At each retune the rule is as follows:
- While the prefetch buffer is full, the limit holds.
- Otherwise, if twice the late count exceeds the useful count, the limit grows by one.
- In every other case it shrinks by one.

Both directions are clamped to the range 1..`DEPTH`.

Both token interfaces use valid/ready. A push is accepted in a cycle where `push_valid` and `push_ready` are both high. A pop is accepted in a cycle where `pop_valid` and `pop_ready` are both high. The producer may hold `push_valid` for as long as it likes under back-pressure. `pop_valid` stays high while a token is outstanding.

Top module: `slip_throttle`

## Requirements
- R1: `push_ready` is high exactly when occupancy is below the current limit. A push is accepted only when `push_valid` and `push_ready` are both high, and then occupancy rises by one in the next cycle.
- R2: `pop_valid` is high exactly when occupancy is nonzero. An accepted pop (`pop_valid` and `pop_ready`) lowers occupancy by one in the next cycle.
- R3: An accepted push and an accepted pop in the same cycle leave occupancy unchanged.
- R4: A reduction of the limit never discards tokens. Occupancy changes only through accepted handshakes. While occupancy is at or above the limit, pushes are refused until pops bring it below.
- R5: A retune happens in the cycle of every `WINDOW`-th accepted pop counted from reset, and the new limit is visible in the next cycle. Both counters then restart from zero, and outcome pulses that arrive in the retune cycle itself are dropped. The limit changes at no other time.
- R6: When `pbuf_full` is high in a retune cycle, the limit stays the same.
- R7: When `pbuf_full` is low and twice the late count is greater than the useful count, the limit rises by one, but not past `DEPTH`.
- R8: In every other retune case the limit falls by one, but not below 1.
- R9: The late and useful counters are `CNT_W` bits wide and saturate at their all-ones value instead of wrapping.
- R10: A synchronous active-high `rst` empties the queue, clears both counters and the pop count, and sets the limit to `DEPTH/2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Prefetch side offers a token |
| push_ready | output | 1 | Queue accepts a token this cycle |
| pop_valid | output | 1 | A token is outstanding |
| pop_ready | input | 1 | Load side takes a token |
| late_pulse | input | 1 | One load saw a late prefetch |
| useful_pulse | input | 1 | One load saw a timely prefetch |
| pbuf_full | input | 1 | Prefetch buffer full; freezes retuning |
| cap_limit | output | $clog2(DEPTH+1) | Current token limit |
| occupancy | output | $clog2(DEPTH+1) | Tokens currently outstanding |

## Verification
The hardest state to reach is a counter at saturation at the moment of a retune. Reaching it takes tens of thousands of outcome pulses inside one window, and the window only closes on pops. The stimulus therefore stops all token traffic and streams 70,000 useful pulses and 3,000 late pulses. It then reopens traffic with the pulses silent until the window closes. A saturating counter gives a decrease. A wrapping one would see 4,464 useful against 6,000 doubled-late and grow instead. The limit clamps and the freeze are reached by steering the pulse mix for many windows. A behavioural model compares occupancy, both ready/valid outputs and the limit on every cycle.

// File: rtl/slip_pkg.sv
package slip_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD   = 2'd0,
    ADJ_GROW   = 2'd1,
    ADJ_SHRINK = 2'd2
  } adj_t;
endpackage

// File: rtl/slip_occupancy.sv
module slip_occupancy #(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic             pop_ready,
  input  logic [OCC_W-1:0] cap_limit,
  output logic             push_ready,
  output logic             pop_valid,
  output logic             push_fire,
  output logic             pop_fire,
  output logic [OCC_W-1:0] occ
);
  logic [OCC_W-1:0] occ_q;

  assign push_ready = occ_q < cap_limit;
  assign pop_valid  = occ_q != '0;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_ready && pop_valid;
  assign occ        = occ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
    end else begin
      case ({push_fire, pop_fire})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  a_r4_within_depth: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> occ_q <= OCC_W'(DEPTH));
  a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
    (push_fire && pop_fire) |=> $stable(occ_q));
  a_r2_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (!push_fire && !pop_fire) |=> $stable(occ_q));
endmodule

// File: rtl/slip_outcome_counters.sv
module slip_outcome_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             late_pulse,
  input  logic             useful_pulse,
  output logic [CNT_W-1:0] late_cnt,
  output logic [CNT_W-1:0] useful_cnt
);
  localparam int LANES = 2;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [LANES-1:0]            pulse;
  logic [LANES-1:0][CNT_W-1:0] cnt_q;

  assign pulse      = {useful_pulse, late_pulse};
  assign late_cnt   = cnt_q[0];
  assign useful_cnt = cnt_q[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear)
        cnt_q[g] <= '0;
      else if (pulse[g] && cnt_q[g] != TOP)
        cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[g] == TOP && !clear) |=> cnt_q[g] == TOP);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
      clear |=> cnt_q[g] == '0);
  end
endmodule

// File: rtl/slip_capacity_tuner.sv
module slip_capacity_tuner
  import slip_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WINDOW = 64,
  parameter int CNT_W  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_fire,
  input  logic             pbuf_full,
  input  logic [CNT_W-1:0] late_cnt,
  input  logic [CNT_W-1:0] useful_cnt,
  output logic             decide,
  output logic [OCC_W-1:0] cap_limit
);
  localparam logic [OCC_W-1:0] CAP_MAX  = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] CAP_INIT = OCC_W'((DEPTH / 2 > 0) ? DEPTH / 2 : 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  logic [WIN_W-1:0] win_q;
  logic [OCC_W-1:0] cap_q;
  logic [CNT_W:0]   late_x2;
  adj_t             adj;

  assign decide    = pop_fire && (win_q == WIN_LAST);
  assign late_x2   = {late_cnt, 1'b0};
  assign cap_limit = cap_q;

  always_comb begin
    if (pbuf_full)
      adj = ADJ_HOLD;
    else if (late_x2 > {1'b0, useful_cnt})
      adj = ADJ_GROW;
    else
      adj = ADJ_SHRINK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      cap_q <= CAP_INIT;
    end else begin
      if (pop_fire)
        win_q <= decide ? '0 : win_q + 1'b1;
      if (decide) begin
        unique case (adj)
          ADJ_GROW:   if (cap_q != CAP_MAX) cap_q <= cap_q + 1'b1;
          ADJ_SHRINK: if (cap_q > OCC_W'(1)) cap_q <= cap_q - 1'b1;
          default:    cap_q <= cap_q;
        endcase
      end
    end
  end

  a_r5_only_at_decide: assert property (@(posedge clk) disable iff (rst)
    !decide |=> $stable(cap_q));
  a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
    (decide && pbuf_full) |=> $stable(cap_q));
  a_r7_grow: assert property (@(posedge clk) disable iff (rst)
    (decide && adj == ADJ_GROW && cap_q != CAP_MAX) |=> cap_q == $past(cap_q) + 1'b1);
  a_r8_bounds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cap_q >= OCC_W'(1) && cap_q <= CAP_MAX));
endmodule

// File: rtl/slip_throttle.sv
module slip_throttle #(
  parameter int DEPTH  = 16,
  parameter int WINDOW = 64,
  parameter int CNT_W  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  output logic             push_ready,
  output logic             pop_valid,
  input  logic             pop_ready,
  input  logic             late_pulse,
  input  logic             useful_pulse,
  input  logic             pbuf_full,
  output logic [OCC_W-1:0] cap_limit,
  output logic [OCC_W-1:0] occupancy
);
  logic             push_fire;
  logic             pop_fire;
  logic             decide;
  logic [CNT_W-1:0] late_cnt;
  logic [CNT_W-1:0] useful_cnt;

  slip_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst(rst), .push_valid(push_valid), .pop_ready(pop_ready),
    .cap_limit(cap_limit), .push_ready(push_ready), .pop_valid(pop_valid),
    .push_fire(push_fire), .pop_fire(pop_fire), .occ(occupancy)
  );

  slip_outcome_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(decide), .late_pulse(late_pulse),
    .useful_pulse(useful_pulse), .late_cnt(late_cnt), .useful_cnt(useful_cnt)
  );

  slip_capacity_tuner #(.DEPTH(DEPTH), .WINDOW(WINDOW), .CNT_W(CNT_W)) u_tune (
    .clk(clk), .rst(rst), .pop_fire(pop_fire), .pbuf_full(pbuf_full),
    .late_cnt(late_cnt), .useful_cnt(useful_cnt), .decide(decide),
    .cap_limit(cap_limit)
  );

  a_r1_push_gate: assert property (@(posedge clk) disable iff (rst)
    (push_valid && occupancy >= cap_limit) |-> !push_ready);
endmodule

// File: tb/test_slip_throttle.sv
module test_slip_throttle;
  localparam int DEPTH  = 16;
  localparam int WINDOW = 64;
  localparam int CNT_W  = 16;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0, pop_ready = 1'b0;
  logic late_pulse = 1'b0, useful_pulse = 1'b0, pbuf_full = 1'b0;
  logic push_ready, pop_valid;
  logic [OCC_W-1:0] cap_limit, occupancy;

  always #2.5 clk = ~clk;

  slip_throttle #(.DEPTH(DEPTH), .WINDOW(WINDOW), .CNT_W(CNT_W)) i_slip_throttle (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .late_pulse(late_pulse),
    .useful_pulse(useful_pulse), .pbuf_full(pbuf_full), .cap_limit(cap_limit),
    .occupancy(occupancy)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  int p_push = 0, p_pop = 0, p_late = 0, p_useful = 0;
  bit done = 0;

  // behavioural reference
  int m_occ = 0, m_cap = DEPTH / 2, m_late = 0, m_useful = 0, m_pops = 0, m_decisions = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_occ = 0; m_cap = DEPTH / 2; m_late = 0; m_useful = 0; m_pops = 0;
    end else begin
      bit pr, pv, pf, qf, dec;
      pr = m_occ < m_cap;
      pv = m_occ > 0;
      pf = push_valid && pr;
      qf = pop_ready && pv;
      dec = 0;
      if (qf) begin
        m_pops++;
        if (m_pops == WINDOW) begin m_pops = 0; dec = 1; end
      end
      if (dec) begin
        m_decisions++;
        if (!pbuf_full) begin
          if (2 * m_late > m_useful) m_cap = (m_cap < DEPTH) ? m_cap + 1 : DEPTH;
          else m_cap = (m_cap > 1) ? m_cap - 1 : 1;
        end
        m_late = 0; m_useful = 0;
      end else begin
        if (late_pulse && m_late < CMAX) m_late++;
        if (useful_pulse && m_useful < CMAX) m_useful++;
      end
      m_occ = m_occ + int'(pf) - int'(qf);
    end
  end

  // compare every cycle, then drive the next inputs
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      check("R1", "push_ready", push_ready, m_occ < m_cap);
      check("R2", "pop_valid", pop_valid, m_occ > 0);
      check("R2/R3/R4", "occupancy", occupancy, m_occ);
      check("R5/R6/R7/R8", "cap_limit", cap_limit, m_cap);
    end
    push_valid   <= ($urandom_range(0, 99) < p_push);
    pop_ready    <= ($urandom_range(0, 99) < p_pop);
    late_pulse   <= ($urandom_range(0, 99) < p_late);
    useful_pulse <= ($urandom_range(0, 99) < p_useful);
    if (cycles > 190000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_decisions(input int n);
    int target;
    target = m_decisions + n;
    while (m_decisions < target) @(negedge clk);
  endtask

  task automatic set_mix(input int pu, input int po, input int la, input int us);
    @(posedge clk);
    p_push = pu; p_pop = po; p_late = la; p_useful = us;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while reset is held
    check("R10", "occupancy at reset", occupancy, 0);
    check("R10", "cap_limit at reset", cap_limit, DEPTH / 2);
    check("R10", "push_ready at reset", push_ready, 1);
    check("R10", "pop_valid at reset", pop_valid, 0);
    rst = 1'b0;

    // R1: fill with no pops, limit 8 stops the producer
    set_mix(100, 0, 0, 0);
    repeat (20) @(negedge clk);
    check("R1", "occupancy full", occupancy, DEPTH / 2);
    check("R1", "push_ready blocked", push_ready, 0);

    // R7: late-heavy traffic drives the limit to the top
    set_mix(70, 70, 50, 20);
    wait_decisions(12);
    @(negedge clk);
    check("R7", "cap at DEPTH", cap_limit, DEPTH);

    // R6: buffer full freezes the limit despite useful-only outcomes
    @(posedge clk); pbuf_full = 1'b1;
    set_mix(70, 70, 0, 80);
    wait_decisions(3);
    @(negedge clk);
    check("R6", "cap frozen", cap_limit, DEPTH);

    // align on a window boundary with the limit at DEPTH
    @(posedge clk); pbuf_full = 1'b0;
    set_mix(70, 70, 100, 0);
    wait_decisions(1);
    // R9: saturate useful, moderate late, no pops
    set_mix(0, 0, 100, 100);
    repeat (3000) @(negedge clk);
    set_mix(0, 0, 0, 100);
    repeat (67000) @(negedge clk);
    set_mix(60, 60, 0, 0);
    wait_decisions(1);
    @(negedge clk);
    check("R9", "cap after saturated window", cap_limit, DEPTH - 1);

    // R8: useful-only drives limit to floor
    set_mix(70, 70, 0, 60);
    wait_decisions(20);
    @(negedge clk);
    check("R8", "cap at floor", cap_limit, 1);

    // R4: at floor the queue holds one token and refuses more
    set_mix(100, 0, 0, 0);
    repeat (5) @(negedge clk);
    check("R4", "occupancy at floor", occupancy, 1);
    check("R4", "push_ready at floor", push_ready, 0);

    set_mix(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule